// File: doc/BRIEF.md
# Bidirectional Scaling Barrel Shifter

This block scales a 40-bit operand by a signed shift count in one cycle and registers the result. The operand is either a 40-bit accumulator value or a 16-bit memory word that is widened into the low half of the datapath. A positive count moves the operand toward the most significant end. A negative count moves it toward the least significant end. The two directions have different reach. A sign-extension mode input decides whether widened memory words and right shifts carry the sign bit or zeros.

The shift count comes from one of four places, picked by a 2-bit select: a field of the current instruction, a field of a status register, the low bits of a temporary register, or the block's own exponent encoder. The exponent encoder always watches the accumulator input. It reports how far that value must move left to be normalized, so a normalization finishes in a single pass through the shifter.

Top module: `scale_shifter`

## Requirements
- R1: While `rst_n` is low, and on the first sampling point after it is released with no clock edge in between, `shift_out` and `exp_out` are both zero.
- R2: `cnt_sel` picks the raw count: 0 selects `imm_cnt`, 1 selects `st_cnt`, 2 selects `t_reg[5:0]`, and 3 selects the exponent of `acc_in`. Each count is a 6-bit two's-complement value, and the sources that are not selected have no effect.
- R3: A count c from 0 to 31 gives `shift_out` = (operand << c) truncated to 40 bits. The c vacated low bits are always 0.
- R4: A count c from -1 to -16 shifts the operand right by |c|. The vacated high bits copy operand bit 39 when `sxm` is 1 and are 0 when `sxm` is 0.
- R5: A raw count below -16 (-17 to -32) acts as -16.
- R6: `src_mem` = 0 selects `acc_in` as the operand. `src_mem` = 1 selects `mem_in` placed in bits 15..0, with bits 39..16 copying `mem_in[15]` when `sxm` is 1 and set to 0 when `sxm` is 0.
- R7: `exp_out` is a 6-bit two's-complement value. It equals the number of bits below bit 39 of `acc_in` that match bit 39 before the first bit that differs, minus 8. An all-zero `acc_in` gives 0, and an all-ones `acc_in` gives 31.
- R8: Both outputs are registered. Each reflects the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_mem | input | 1 | Operand select: 0 accumulator, 1 memory word |
| sxm | input | 1 | Sign-extension mode: 1 sign-fill, 0 zero-fill |
| cnt_sel | input | 2 | Count source select |
| imm_cnt | input | 6 | Instruction-field count |
| st_cnt | input | 6 | Status-register count field |
| t_reg | input | 16 | Temporary register; its low 6 bits serve as the count |
| acc_in | input | 40 | Accumulator operand, also the exponent encoder input |
| mem_in | input | 16 | Memory word operand |
| shift_out | output | 40 | Registered scaled result |
| exp_out | output | 6 | Registered normalization exponent |

## Verification
Both results leave through one register, so each one is due exactly one rising edge after its inputs are applied. The bench changes inputs on a falling edge and reads both outputs on the next falling edge, after the single intervening rising edge has loaded them. Each reading is compared with values the bench computes arithmetically for the inputs applied half a cycle before that edge. Reset is checked at a falling edge while `rst_n` is low, so no load from live inputs can be mistaken for the cleared state.

// File: rtl/scale_shifter.sv
module scale_shifter #(
  parameter int DW   = 40,
  parameter int MW   = 16,
  parameter int CW   = 6,
  parameter int TW   = 16,
  parameter int LMAX = 31,
  parameter int RMAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_mem,
  input  logic          sxm,
  input  logic [1:0]    cnt_sel,
  input  logic [CW-1:0] imm_cnt,
  input  logic [CW-1:0] st_cnt,
  input  logic [TW-1:0] t_reg,
  input  logic [DW-1:0] acc_in,
  input  logic [MW-1:0] mem_in,
  output logic [DW-1:0] shift_out,
  output logic [CW-1:0] exp_out
);
  localparam int BIAS = DW - 32;

  logic [DW-1:0]        opnd;
  logic signed [CW-1:0] exp_val;
  logic signed [CW-1:0] raw_cnt;
  int                   cnt;
  logic [DW-1:0]        shifted;

  assign opnd = src_mem ? {{(DW-MW){sxm & mem_in[MW-1]}}, mem_in} : acc_in;

  always_comb begin
    int  rsb;
    logic run;
    rsb = 0;
    run = 1'b1;
    for (int i = DW-2; i >= 0; i--) begin
      if (run && (acc_in[i] == acc_in[DW-1])) rsb = rsb + 1;
      else run = 1'b0;
    end
    if (acc_in == '0) exp_val = '0;
    else              exp_val = CW'(rsb - BIAS);
  end

  always_comb begin
    case (cnt_sel)
      2'd0:    raw_cnt = imm_cnt;
      2'd1:    raw_cnt = st_cnt;
      2'd2:    raw_cnt = t_reg[CW-1:0];
      default: raw_cnt = exp_val;
    endcase
  end

  always_comb begin
    cnt = int'(raw_cnt);
    if (cnt < -RMAX)     cnt = -RMAX;
    else if (cnt > LMAX) cnt = LMAX;
  end

  always_comb begin
    logic [2*DW-1:0] wide;
    logic            fill;
    fill = sxm & opnd[DW-1];
    wide = '0;
    if (cnt >= 0) begin
      shifted = opnd << cnt;
    end else begin
      wide    = {{DW{fill}}, opnd} >> (-cnt);
      shifted = wide[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_out <= '0;
      exp_out   <= '0;
    end else begin
      shift_out <= shifted;
      exp_out   <= exp_val;
    end
  end

  assert_low_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > 0) |=> (shift_out[0] == 1'b0));

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < 0 && !sxm) |=> (shift_out[DW-1] == 1'b0));

  assert_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < 0 && sxm) |=> (shift_out[DW-1] == $past(opnd[DW-1])));

  assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 0) |=> (shift_out == $past(opnd)));

  assert_exp_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_in == '0) |=> (exp_out == '0));

  assert_mem_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mem && !sxm && cnt <= 0) |=> (shift_out[DW-1:MW] == '0));
endmodule

// File: tb/scale_shifter_tb.sv
module scale_shifter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_mem = 1'b0;
  logic        sxm = 1'b0;
  logic [1:0]  cnt_sel = 2'd0;
  logic [5:0]  imm_cnt = '0;
  logic [5:0]  st_cnt = '0;
  logic [15:0] t_reg = '0;
  logic [39:0] acc_in = '0;
  logic [15:0] mem_in = '0;
  logic [39:0] shift_out;
  logic [5:0]  exp_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scale_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .src_mem(src_mem), .sxm(sxm), .cnt_sel(cnt_sel),
    .imm_cnt(imm_cnt), .st_cnt(st_cnt), .t_reg(t_reg), .acc_in(acc_in),
    .mem_in(mem_in), .shift_out(shift_out), .exp_out(exp_out)
  );

  function automatic int ref_exp(logic [39:0] v);
    int  n;
    bit  go;
    n = 0;
    go = 1;
    if (v == 40'd0) return 0;
    for (int i = 38; i >= 0; i--) begin
      if (go && v[i] == v[39]) n++;
      else go = 0;
    end
    return n - 8;
  endfunction

  function automatic logic [39:0] ref_shift(logic [39:0] op, int c, bit sx);
    longint s;
    if (c < -16) c = -16;
    if (c >= 0) return 40'(op << c);
    if (sx) begin
      s = longint'({{24{op[39]}}, op});
      s = s >>> (-c);
    end else begin
      s = longint'({24'd0, op}) >> (-c);
    end
    return s[39:0];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic step_check(string req, int c);
    logic [39:0] op;
    logic [39:0] e_sh;
    int          e_ex;
    op   = src_mem ? (sxm ? {{24{mem_in[15]}}, mem_in} : {24'd0, mem_in}) : acc_in;
    e_sh = ref_shift(op, c, sxm);
    e_ex = ref_exp(acc_in);
    @(negedge clk);
    check(req, {24'd0, shift_out}, {24'd0, e_sh});
    check("R7", {58'd0, exp_out}, {58'd0, 6'(e_ex)});
  endtask

  logic [39:0] accs [4];
  logic [15:0] mems [2];

  initial begin
    accs[0] = 40'h80_0000_0001;
    accs[1] = 40'h12_3456_789A;
    accs[2] = 40'hFF_FFFF_FFFF;
    accs[3] = 40'h7F_F0F0_0F0F;
    mems[0] = 16'h8421;
    mems[1] = 16'h7FFE;
    acc_in  = 40'hAB_CDEF_1234;
    imm_cnt = 6'd5;
    @(negedge clk);
    @(negedge clk);
    check("R1", {24'd0, shift_out}, 64'd0);
    check("R1", {58'd0, exp_out}, 64'd0);
    rst_n = 1'b1;
    #1;
    check("R1", {24'd0, shift_out}, 64'd0);

    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 2; x++)
        for (int sel = 0; sel < 3; sel++)
          for (int k = 0; k < 4; k++)
            for (int c = -32; c < 32; c++) begin
              src_mem = s[0];
              sxm     = x[0];
              cnt_sel = 2'(sel);
              acc_in  = accs[k];
              mem_in  = mems[k % 2];
              imm_cnt = (sel == 0) ? 6'(c) : ~6'(c);
              st_cnt  = (sel == 1) ? 6'(c) : 6'(c + 7);
              t_reg   = (sel == 2) ? {10'h2A5, 6'(c)} : {10'h15A, 6'(c + 13)};
              if (c < -16)     step_check("R5", c);
              else if (c < 0)  step_check(s ? "R6/R4" : "R4", c);
              else if (sel==2) step_check("R2", c);
              else             step_check(s ? "R6/R3" : "R3/R8", c);
            end

    src_mem = 1'b0;
    cnt_sel = 2'd3;
    for (int x = 0; x < 2; x++)
      for (int k = 0; k < 40; k++)
        for (int n = 0; n < 2; n++) begin
          sxm    = x[0];
          acc_in = n ? ~(40'd1 << k) : (40'd1 << k);
          imm_cnt = 6'd1;
          step_check("R2 normalize", ref_exp(acc_in));
        end
    acc_in = 40'd0;
    step_check("R7 zero", 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule